// File: doc/BRIEF.md
# Vector Element Reversal Unit

This block takes one 32-bit vector-reverse instruction word together with the source vector read for it. It decodes the instruction and returns the reversed vector one clock later. The instruction selects three things. The container width is 16, 32 or 64 bits. The element width is 8, 16 or 32 bits. The vector is either 64 or 128 bits wide. Inside every container the elements are written back in the opposite order, and each container keeps its own place in the result. Elements are moved as raw bits; the kind of data they hold plays no part.

The block also decodes the 5-bit destination and source register numbers and returns them next to the result. An instruction word whose fixed bits do not fit the reverse pattern is not recognised: the match output stays low, and valid, undefined and the result all stay at zero. A recognised word whose fields ask for an impossible operation raises the undefined flag instead of valid, and its result is zero. The register file, access control and conditional execution are handled elsewhere.

Top module: `vrev_unit`

## Requirements
- R1: While rst_n is low, and until the first strobe after reset, out_valid, out_undef and out_match are low.
- R2: An instruction word is recognised only when its fixed bits hold their set values: bits 31..23 = 1, bits 21..20 = 11, bits 17..16 = 00, bits 11..9 = 000 and bit 4 = 0 (mask 0xFFB30E10, value 0xFFB00000). For an unrecognised word, out_match, out_valid and out_undef are 0 and out_result is all zeros.
- R3: out_dst_idx = {instr[22], instr[15:12]} and out_src_idx = {instr[5], instr[3:0]}, loaded on every strobe.
- R4: instr[8:7] selects the container: 00 = 64 bits, 01 = 32 bits, 10 = 16 bits.
- R5: instr[19:18] selects the element: 00 = 8 bits, 01 = 16 bits, 10 = 32 bits.
- R6: A recognised word is undefined when instr[19:18] = 11, or when op + size >= 3 (the element is not narrower than the container, and op = 11 always counts). In that case out_undef = 1, out_valid = 0 and out_result is zero.
- R7: When instr[6] = 1, the word is undefined if instr[12] or instr[0] is 1 (an odd destination or source register).
- R8: instr[6] = 0 works on src_vec[63:0] and drives out_result[127:64] to zero. instr[6] = 1 works on all 128 bits.
- R9: The outputs appear on the clock edge after the edge that samples in_valid = 1. After a cycle with no strobe, the three flags are low and the result and indices keep their previous values.
- R10: For a legal word, element k of each container in the result equals element n-1-k of the same container in the source, where n is the number of elements per container.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| in_valid | input | 1 | Strobe: sample instr and src_vec on this edge |
| instr | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector; only the low 64 bits are used when instr[6] = 0 |
| out_valid | output | 1 | The result belongs to a legal, recognised word |
| out_undef | output | 1 | The word was recognised but its fields are illegal |
| out_match | output | 1 | The word's fixed bits fit the reverse pattern |
| out_result | output | 128 | Reversed vector, or zero |
| out_dst_idx | output | 5 | Destination register number |
| out_src_idx | output | 5 | Source register number |

## Verification
The hardest cases to reach are the ones where the decode rules overlap. An example is a quadword word with an odd register number whose op and size fields are also illegal, or a word that is one fixed bit away from a legal one. The bench sweeps every combination of op, size, the vector-width bit and the low bits of both register numbers. For each one it works out from the field rules alone whether the word is legal, undefined or reversed. It then takes a legal word and flips each fixed bit of the pattern in turn, so that every position of the recognition mask is tested on its own.

// File: rtl/vrev_pkg.sv
package vrev_pkg;

  localparam int INSN_W   = 32;
  localparam int REG_IDX_W = 5;

  // fixed-bit recognition pattern
  localparam logic [INSN_W-1:0] FIX_MASK  = 32'hFFB3_0E10;
  localparam logic [INSN_W-1:0] FIX_VALUE = 32'hFFB0_0000;

  // field positions
  localparam int POS_DHI   = 22;
  localparam int POS_ESZ   = 18;
  localparam int POS_VD    = 12;
  localparam int POS_OP    = 7;
  localparam int POS_Q     = 6;
  localparam int POS_MHI   = 5;
  localparam int POS_VM    = 0;

  typedef enum logic [1:0] {
    CONT_64 = 2'b00,
    CONT_32 = 2'b01,
    CONT_16 = 2'b10,
    CONT_RSV = 2'b11
  } cont_e;

  typedef enum logic [1:0] {
    ELEM_8  = 2'b00,
    ELEM_16 = 2'b01,
    ELEM_32 = 2'b10,
    ELEM_RSV = 2'b11
  } elem_e;

  typedef struct packed {
    logic                 match;
    logic                 legal;
    logic                 undef;
    logic                 quad;
    cont_e                cont;
    elem_e                elem;
    logic [REG_IDX_W-1:0] dst;
    logic [REG_IDX_W-1:0] src;
  } dec_t;

endpackage

// File: rtl/vrev_rst_sync.sv
module vrev_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/vrev_decode.sv
module vrev_decode
  import vrev_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output dec_t              dec
);

  logic       pat_ok;
  logic [1:0] op_f;
  logic [1:0] esz_f;
  logic       q_f;
  logic       size_bad;
  logic       nest_bad;
  logic       reg_bad;
  logic       any_bad;

  always_comb begin
    pat_ok   = (instr & FIX_MASK) == FIX_VALUE;
    op_f     = instr[POS_OP +: 2];
    esz_f    = instr[POS_ESZ +: 2];
    q_f      = instr[POS_Q];
    size_bad = (esz_f == 2'b11);
    nest_bad = ({1'b0, op_f} + {1'b0, esz_f}) >= 3'd3;
    reg_bad  = q_f && (instr[POS_VD] || instr[POS_VM]);
    any_bad  = size_bad || nest_bad || reg_bad;

    dec.match = pat_ok;
    dec.legal = pat_ok && !any_bad;
    dec.undef = pat_ok && any_bad;
    dec.quad  = q_f;
    dec.cont  = cont_e'(op_f);
    dec.elem  = elem_e'(esz_f);
    dec.dst   = {instr[POS_DHI], instr[POS_VD +: 4]};
    dec.src   = {instr[POS_MHI], instr[POS_VM +: 4]};
  end

endmodule

// File: rtl/vrev_permute.sv
module vrev_permute
  import vrev_pkg::*;
#(
  parameter int LANE_W    = 8,
  parameter int VEC_LANES = 16,
  parameter int GRP_LANES = 8,
  localparam int VEC_W     = LANE_W * VEC_LANES,
  localparam int GRP_IDX_W = $clog2(GRP_LANES),
  localparam int VEC_IDX_W = $clog2(VEC_LANES)
) (
  input  logic [VEC_W-1:0] data_in,
  input  cont_e            cont,
  input  elem_e            elem,
  input  logic             quad,
  output logic [VEC_W-1:0] data_out
);

  logic [VEC_LANES-1:0][LANE_W-1:0] lanes_in;
  logic [VEC_LANES-1:0][LANE_W-1:0] lanes_out;
  logic [GRP_IDX_W-1:0]             cont_mask;
  logic [GRP_IDX_W-1:0]             elem_mask;
  logic [GRP_IDX_W-1:0]             flip;

  assign lanes_in = data_in;

  // Reversing n elements inside a power-of-two container is an XOR of the
  // lane offset with the container mask minus the element mask.
  always_comb begin
    cont_mask = GRP_IDX_W'((GRP_LANES >> cont) - 1);
    elem_mask = GRP_IDX_W'((1 << elem) - 1);
    flip      = cont_mask & ~elem_mask;
  end

  for (genvar g = 0; g < VEC_LANES; g++) begin : g_lane
    localparam int                   BASE   = (g / GRP_LANES) * GRP_LANES;
    localparam logic [GRP_IDX_W-1:0] OFFSET = GRP_IDX_W'(g % GRP_LANES);
    localparam logic [VEC_IDX_W-1:0] BASE_V = VEC_IDX_W'(BASE);
    logic [VEC_IDX_W-1:0] pick;

    assign pick = BASE_V | VEC_IDX_W'(OFFSET ^ flip);

    if (g >= GRP_LANES) begin : g_upper
      assign lanes_out[g] = quad ? lanes_in[pick] : '0;
    end else begin : g_lower
      assign lanes_out[g] = lanes_in[pick];
    end
  end

  assign data_out = lanes_out;

endmodule

// File: rtl/vrev_outreg.sv
module vrev_outreg
  import vrev_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  dec_t                 dec,
  input  logic [VEC_W-1:0]     result_d,
  output logic                 valid_q,
  output logic                 undef_q,
  output logic                 match_q,
  output logic [VEC_W-1:0]     result_q,
  output logic [REG_IDX_W-1:0] dst_q,
  output logic [REG_IDX_W-1:0] src_q
);

  logic valid_d;
  logic undef_d;
  logic match_d;

  always_comb begin
    valid_d = load && dec.legal;
    undef_d = load && dec.undef;
    match_d = load && dec.match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      undef_q <= 1'b0;
      match_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      undef_q <= undef_d;
      match_q <= match_d;
    end
  end

  // data path: enable only, no reset
  always_ff @(posedge clk) begin
    if (load) begin
      result_q <= dec.legal ? result_d : '0;
      dst_q    <= dec.dst;
      src_q    <= dec.src;
    end
  end

endmodule

// File: rtl/vrev_unit.sv
module vrev_unit
  import vrev_pkg::*;
#(
  parameter int LANE_W    = 8,
  parameter int VEC_LANES = 16,
  parameter int GRP_LANES = 8,
  localparam int VEC_W    = LANE_W * VEC_LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [INSN_W-1:0]    instr,
  input  logic [VEC_W-1:0]     src_vec,
  output logic                 out_valid,
  output logic                 out_undef,
  output logic                 out_match,
  output logic [VEC_W-1:0]     out_result,
  output logic [REG_IDX_W-1:0] out_dst_idx,
  output logic [REG_IDX_W-1:0] out_src_idx
);

  logic             rst_n_int;
  dec_t             dec;
  logic [VEC_W-1:0] permuted;

  vrev_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  vrev_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  vrev_permute #(
    .LANE_W    (LANE_W),
    .VEC_LANES (VEC_LANES),
    .GRP_LANES (GRP_LANES)
  ) u_perm (
    .data_in  (src_vec),
    .cont     (dec.cont),
    .elem     (dec.elem),
    .quad     (dec.quad),
    .data_out (permuted)
  );

  vrev_outreg #(.VEC_W(VEC_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (in_valid),
    .dec      (dec),
    .result_d (permuted),
    .valid_q  (out_valid),
    .undef_q  (out_undef),
    .match_q  (out_match),
    .result_q (out_result),
    .dst_q    (out_dst_idx),
    .src_q    (out_src_idx)
  );

endmodule

// File: rtl/vrev_unit_chk.sv
module vrev_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [31:0]      instr,
  input logic [VEC_W-1:0] src_vec,
  input logic             out_valid,
  input logic             out_undef,
  input logic             out_match,
  input logic [VEC_W-1:0] out_result,
  input logic [4:0]       out_dst_idx,
  input logic [4:0]       out_src_idx
);

  logic pat_ok;
  assign pat_ok = (instr & 32'hFFB3_0E10) == 32'hFFB0_0000;

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_undef && !out_match));

  // R2
  flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_undef) |-> out_match);

  // R2
  bad_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pat_ok) |=> (!out_match && !out_valid && out_result == '0));

  // R6
  size_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pat_ok && instr[19:18] == 2'b11) |=> (out_undef && !out_valid));

  // R7
  quad_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pat_ok && instr[6] && (instr[12] || instr[0])) |=> (out_undef && !out_valid));

  // R8
  dword_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !instr[6]) |=> (out_result[VEC_W-1:VEC_W/2] == '0));

  // R3
  dst_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_dst_idx == $past({instr[22], instr[15:12]})
                  && out_src_idx == $past({instr[5], instr[3:0]})));

  // R6
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_undef |-> (out_result == '0 && !out_valid));

endmodule

bind vrev_unit vrev_unit_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/tb_vrev_unit.sv
module tb_vrev_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  instr;
  logic [127:0] src_vec;
  logic         out_valid;
  logic         out_undef;
  logic         out_match;
  logic [127:0] out_result;
  logic [4:0]   out_dst_idx;
  logic [4:0]   out_src_idx;

  int total = 0;
  int bad   = 0;

  vrev_unit dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .instr       (instr),
    .src_vec     (src_vec),
    .out_valid   (out_valid),
    .out_undef   (out_undef),
    .out_match   (out_match),
    .out_result  (out_result),
    .out_dst_idx (out_dst_idx),
    .out_src_idx (out_src_idx)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int op, input int esz, input int q,
                                     input int d, input int vd, input int m, input int vm);
    logic [31:0] w;
    w = 32'hFFB0_0000;
    w[22]    = d[0];
    w[19:18] = esz[1:0];
    w[15:12] = vd[3:0];
    w[8:7]   = op[1:0];
    w[6]     = q[0];
    w[5]     = m[0];
    w[3:0]   = vm[3:0];
    return w;
  endfunction

  function automatic logic [127:0] pattern(input int seed);
    logic [127:0] v;
    for (int b = 0; b < 16; b++) v[b*8 +: 8] = 8'((seed * 29 + b * 37 + 1) & 255);
    return v;
  endfunction

  // arithmetic model of the reversal
  function automatic logic [127:0] model(input logic [127:0] v, input int op,
                                         input int esz, input int q);
    logic [127:0] r;
    int c, e, base, o, k, j, s;
    r = '0;
    c = 8 >> op;
    e = 1 << esz;
    for (int b = 0; b < 16; b++) begin
      if (q != 0 || b < 8) begin
        base = b - (b % c);
        o    = b % c;
        k    = o / e;
        j    = o % e;
        s    = base + (c / e - 1 - k) * e + j;
        r[b*8 +: 8] = v[s*8 +: 8];
      end
    end
    return r;
  endfunction

  task automatic strobe(input logic [31:0] w, input logic [127:0] v);
    @(negedge clk);
    in_valid = 1'b1;
    instr    = w;
    src_vec  = v;
    @(negedge clk);
    in_valid = 1'b0;
    instr    = ~w;
    src_vec  = ~v;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=%0d exp=0", WATCHDOG);
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    logic [31:0]  w;
    logic [127:0] v;
    logic [127:0] exp_r;
    bit           exp_u;
    bit           legal;
    int           n;

    rst_n    = 1'b0;
    in_valid = 1'b0;
    instr    = '0;
    src_vec  = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!out_valid && !out_undef && !out_match, "R1 flags in reset",
          {125'b0, out_valid, out_undef, out_match}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!out_valid && !out_undef && !out_match, "R1 flags after release",
          {125'b0, out_valid, out_undef, out_match}, '0);

    // full sweep of op, size, q and register low bits: R4 R5 R6 R7 R8 R10 R3
    n = 0;
    for (int op = 0; op < 4; op++)
      for (int esz = 0; esz < 4; esz++)
        for (int q = 0; q < 2; q++)
          for (int rl = 0; rl < 4; rl++) begin
            int vd, vm, d, m;
            vd = ((n * 3) & 14) | (rl & 1);
            vm = ((n * 5) & 14) | ((rl >> 1) & 1);
            d  = n & 1;
            m  = (n >> 1) & 1;
            w  = mk(op, esz, q, d, vd, m, vm);
            v  = pattern(n);
            exp_u = (esz == 3) || (op + esz >= 3) || (q == 1 && ((vd & 1) == 1 || (vm & 1) == 1));
            legal = !exp_u;
            exp_r = legal ? model(v, op, esz, q) : '0;
            strobe(w, v);
            check(out_match && out_valid == legal && out_undef == exp_u,
                  $sformatf("R6 R7 flags op=%0d esz=%0d q=%0d", op, esz, q),
                  {125'b0, out_match, out_valid, out_undef},
                  {125'b0, 1'b1, legal, exp_u});
            check(out_result == exp_r,
                  $sformatf("R10 R4 R5 R8 result op=%0d esz=%0d q=%0d", op, esz, q),
                  out_result, exp_r);
            check(out_dst_idx == 5'(d * 16 + vd) && out_src_idx == 5'(m * 16 + vm),
                  "R3 indices", {118'b0, out_dst_idx, out_src_idx},
                  {118'b0, 5'(d * 16 + vd), 5'(m * 16 + vm)});
            // R9: idle cycle clears flags, holds data
            @(negedge clk);
            check(!out_valid && !out_undef && !out_match && out_result == exp_r,
                  "R9 idle hold", out_result, exp_r);
            n++;
          end

    // R2: flip every fixed bit of a legal word
    for (int bpos = 0; bpos < 32; bpos++) begin
      logic [31:0] mask;
      mask = 32'hFFB3_0E10;
      if (mask[bpos]) begin
        w = mk(0, 0, 1, 1, 4, 0, 6);
        w[bpos] = ~w[bpos];
        v = pattern(bpos + 100);
        strobe(w, v);
        check(!out_match && !out_valid && !out_undef && out_result == '0,
              $sformatf("R2 fixed bit %0d", bpos), out_result, '0);
      end
    end

    // R2 positive after negatives, R9 back-to-back strobes
    w = mk(1, 0, 0, 0, 3, 1, 9);
    v = pattern(7);
    @(negedge clk);
    in_valid = 1'b1; instr = w; src_vec = v;
    @(negedge clk);
    check(out_valid && out_result == model(v, 1, 0, 0), "R9 first of pair",
          out_result, model(v, 1, 0, 0));
    w = mk(0, 1, 1, 0, 2, 0, 4);
    instr = w; src_vec = ~v;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_result == model(~v, 0, 1, 1), "R9 second of pair",
          out_result, model(~v, 0, 1, 1));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule